// File: doc/BRIEF.md
# Snoop-Behind-Completion Ordering Queue

This unit sits on the host-to-device ingress path in front of a caching agent. It accepts two independent message streams, completions (global-observation responses) and snoops, each on its own valid/ready input, and hands them on through two valid/ready outputs, one per class. The two classes are otherwise unordered. One rule is enforced: a snoop may not reach the agent before any completion to the same cache line that was accepted before it. Without this rule, the agent could answer a snoop as if it did not hold a line that is already granted to it.

Completions wait in an in-order tracker. When a snoop is accepted, its cache-line address is compared against the line address of every completion still pending. The snoop records the set of matching tracker slots as a dependency mask. Each completion that leaves the tracker clears its bit in every snoop's mask. A snoop is offered at the output once its mask is empty and it reaches the head of the snoop queue. A snoop with no dependency can therefore overtake older completions to other lines, for example while the completion output is back-pressured.

Top module: `snoop_order_queue`

## Requirements
- R1: While reset is asserted and right after it is released, `cmp_out_valid` and `snp_out_valid` are low, and `cmp_in_ready` and `snp_in_ready` are high.
- R2: Completions leave on the completion output in the order they were accepted, with their address and tag unchanged.
- R3: A snoop with no pending same-line completion is offered on `snp_out_valid` in the cycle after it is accepted, even while older completions to other lines are still held because `cmp_out_ready` is low.
- R4: A snoop whose line matches one or more pending completions keeps `snp_out_valid` low until all of those completions have been accepted at the completion output. It is offered right after the clock edge at which the last of them is accepted.
- R5: Two addresses fall on the same line when they agree in every bit above the low log2(LINE_BYTES) offset bits. With the default of 64, bits [5:0] are ignored and a difference in bit 6 means a different line.
- R6: A completion accepted in the same cycle as a snoop, or later, never holds that snoop back, even when both address the same line.
- R7: The completion tracker holds CMP_DEPTH entries (8 by default). When it is full, `cmp_in_ready` is low, an offered completion is not taken, and no entry is lost or duplicated.
- R8: The snoop queue holds SNP_DEPTH entries (4 by default). When it is full, `snp_in_ready` is low. Snoops leave in the order they were accepted.
- R9: An output whose valid is high while its ready is low keeps valid high, and its address and tag stable, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_in_valid | input | 1 | Completion offered |
| cmp_in_ready | output | 1 | Completion tracker can accept |
| cmp_in_addr | input | ADDR_W | Completion byte address |
| cmp_in_tag | input | TAG_W | Completion identifier, carried through |
| snp_in_valid | input | 1 | Snoop offered |
| snp_in_ready | output | 1 | Snoop queue can accept |
| snp_in_addr | input | ADDR_W | Snoop byte address |
| snp_in_tag | input | TAG_W | Snoop identifier, carried through |
| cmp_out_valid | output | 1 | Completion presented to the agent |
| cmp_out_ready | input | 1 | Agent takes the completion |
| cmp_out_addr | output | ADDR_W | Presented completion address |
| cmp_out_tag | output | TAG_W | Presented completion identifier |
| snp_out_valid | output | 1 | Snoop presented to the agent |
| snp_out_ready | input | 1 | Agent takes the snoop |
| snp_out_addr | output | ADDR_W | Presented snoop address |
| snp_out_tag | output | TAG_W | Presented snoop identifier |

## Verification
The bench builds the unit with its defaults: 32-bit addresses, 4-bit tags, an eight-entry completion tracker, a four-entry snoop queue and 64-byte lines. Both queues are shallow, so a handful of directed pushes fills each one and exercises back-pressure. The offset width of six lets a pair of addresses straddle bit 6 to separate the same-line case from the neighbouring-line case. With eight tracker slots, a snoop can depend on two non-adjacent slots while an unrelated completion sits between them.

// File: rtl/sbo_pkg.sv
package sbo_pkg;
    // Index width for a circular buffer; never below one bit.
    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Occupancy counter width able to hold the value depth.
    function automatic int cnt_width(input int depth);
        return $clog2(depth + 1);
    endfunction
endpackage

// File: rtl/sbo_cmp_tracker.sv
module sbo_cmp_tracker #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4,
    parameter int DEPTH  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [ADDR_W-1:0]             push_addr,
    input  logic [TAG_W-1:0]              push_tag,
    input  logic                          pop,
    output logic [DEPTH-1:0]              occ,
    output logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    output logic [DEPTH-1:0]              head_onehot,
    output logic [ADDR_W-1:0]             head_addr,
    output logic [TAG_W-1:0]              head_tag,
    output logic                          empty,
    output logic                          full
);
    localparam int IDX_W = sbo_pkg::idx_width(DEPTH);
    localparam int CNT_W = sbo_pkg::cnt_width(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0]             occ;
        logic [IDX_W-1:0]             wr;
        logic [IDX_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } trk_t;

    trk_t q, d;

    always_comb begin
        d = q;
        if (pop) begin
            d.occ[q.rd] = 1'b0;
            d.rd = (q.rd == IDX_W'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        end
        if (push) begin
            d.addr[q.wr] = push_addr;
            d.tag[q.wr]  = push_tag;
            d.occ[q.wr]  = 1'b1;
            d.wr = (q.wr == IDX_W'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        end
        d.cnt = q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        head_onehot = '0;
        head_onehot[q.rd] = 1'b1;
    end

    assign occ       = q.occ;
    assign slot_addr = q.addr;
    assign head_addr = q.addr[q.rd];
    assign head_tag  = q.tag[q.rd];
    assign empty     = (q.cnt == '0);
    assign full      = (q.cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/sbo_line_match.sv
module sbo_line_match #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    parameter int OFS_W  = 6
) (
    input  logic [ADDR_W-1:0]             probe_addr,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    input  logic [DEPTH-1:0]              occ,
    output logic [DEPTH-1:0]              hit
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        assign hit[s] = occ[s] &&
            (slot_addr[s][ADDR_W-1:OFS_W] == probe_addr[ADDR_W-1:OFS_W]);
    end
endmodule

// File: rtl/sbo_snp_queue.sv
module sbo_snp_queue #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4,
    parameter int DEPTH  = 4,
    parameter int CDEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [ADDR_W-1:0]    push_addr,
    input  logic [TAG_W-1:0]     push_tag,
    input  logic [CDEPTH-1:0]    push_mask,
    input  logic [CDEPTH-1:0]    clr,
    input  logic                 pop,
    output logic                 head_valid,
    output logic [ADDR_W-1:0]    head_addr,
    output logic [TAG_W-1:0]     head_tag,
    output logic                 full
);
    localparam int IDX_W = sbo_pkg::idx_width(DEPTH);
    localparam int CNT_W = sbo_pkg::cnt_width(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0][CDEPTH-1:0] mask;
        logic [IDX_W-1:0]             wr;
        logic [IDX_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } snq_t;

    snq_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < DEPTH; i++) begin
            d.mask[i] = q.mask[i] & ~clr;
        end
        if (pop) begin
            d.rd = (q.rd == IDX_W'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        end
        if (push) begin
            d.addr[q.wr] = push_addr;
            d.tag[q.wr]  = push_tag;
            d.mask[q.wr] = push_mask;
            d.wr = (q.wr == IDX_W'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        end
        d.cnt = q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head_valid = (q.cnt != '0) && (q.mask[q.rd] == '0);
    assign head_addr  = q.addr[q.rd];
    assign head_tag   = q.tag[q.rd];
    assign full       = (q.cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/snoop_order_queue.sv
module snoop_order_queue #(
    parameter int ADDR_W     = 32,
    parameter int TAG_W      = 4,
    parameter int CMP_DEPTH  = 8,
    parameter int SNP_DEPTH  = 4,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_in_valid,
    output logic              cmp_in_ready,
    input  logic [ADDR_W-1:0] cmp_in_addr,
    input  logic [TAG_W-1:0]  cmp_in_tag,
    input  logic              snp_in_valid,
    output logic              snp_in_ready,
    input  logic [ADDR_W-1:0] snp_in_addr,
    input  logic [TAG_W-1:0]  snp_in_tag,
    output logic              cmp_out_valid,
    input  logic              cmp_out_ready,
    output logic [ADDR_W-1:0] cmp_out_addr,
    output logic [TAG_W-1:0]  cmp_out_tag,
    output logic              snp_out_valid,
    input  logic              snp_out_ready,
    output logic [ADDR_W-1:0] snp_out_addr,
    output logic [TAG_W-1:0]  snp_out_tag
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    logic                            trk_empty, trk_full;
    logic [CMP_DEPTH-1:0]            trk_occ, trk_head_oh, line_hit;
    logic [CMP_DEPTH-1:0][ADDR_W-1:0] trk_addr;
    logic                            snq_full, snq_head_valid;
    logic                            cmp_push, cmp_pop, snp_push, snp_pop;
    logic [CMP_DEPTH-1:0]            leave_mask, dep_mask;

    assign cmp_in_ready = !trk_full;
    assign snp_in_ready = !snq_full;
    assign cmp_push     = cmp_in_valid && cmp_in_ready;
    assign snp_push     = snp_in_valid && snp_in_ready;
    assign cmp_out_valid = !trk_empty;
    assign cmp_pop      = cmp_out_valid && cmp_out_ready;
    assign snp_out_valid = snq_head_valid;
    assign snp_pop      = snp_out_valid && snp_out_ready;

    // A completion leaving this cycle no longer counts as pending.
    always_comb begin
        leave_mask = cmp_pop ? trk_head_oh : '0;
        dep_mask   = line_hit & ~leave_mask;
    end

    sbo_cmp_tracker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .DEPTH(CMP_DEPTH)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .push(cmp_push), .push_addr(cmp_in_addr), .push_tag(cmp_in_tag),
        .pop(cmp_pop),
        .occ(trk_occ), .slot_addr(trk_addr), .head_onehot(trk_head_oh),
        .head_addr(cmp_out_addr), .head_tag(cmp_out_tag),
        .empty(trk_empty), .full(trk_full)
    );

    sbo_line_match #(.ADDR_W(ADDR_W), .DEPTH(CMP_DEPTH), .OFS_W(OFS_W)) u_match (
        .probe_addr(snp_in_addr), .slot_addr(trk_addr), .occ(trk_occ),
        .hit(line_hit)
    );

    sbo_snp_queue #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .DEPTH(SNP_DEPTH),
                    .CDEPTH(CMP_DEPTH)) u_snq (
        .clk(clk), .rst_n(rst_n),
        .push(snp_push), .push_addr(snp_in_addr), .push_tag(snp_in_tag),
        .push_mask(dep_mask), .clr(leave_mask), .pop(snp_pop),
        .head_valid(snq_head_valid), .head_addr(snp_out_addr),
        .head_tag(snp_out_tag), .full(snq_full)
    );
endmodule

// File: rtl/sbo_checker.sv
module sbo_checker #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_in_ready,
    input logic              cmp_out_valid,
    input logic              cmp_out_ready,
    input logic [ADDR_W-1:0] cmp_out_addr,
    input logic [TAG_W-1:0]  cmp_out_tag,
    input logic              snp_out_valid,
    input logic              snp_out_ready,
    input logic [ADDR_W-1:0] snp_out_addr,
    input logic [TAG_W-1:0]  snp_out_tag
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (!cmp_out_valid && !snp_out_valid);
        end
    end

    a_r9_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_out_valid && !cmp_out_ready) |=>
        (cmp_out_valid && $stable(cmp_out_addr) && $stable(cmp_out_tag)));

    a_r9_snp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_out_valid && !snp_out_ready) |=>
        (snp_out_valid && $stable(snp_out_addr) && $stable(snp_out_tag)));

    a_r7_full_has_head: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_in_ready |-> cmp_out_valid);

    a_r7_empty_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_out_valid |-> cmp_in_ready);
endmodule

bind snoop_order_queue sbo_checker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_sbo_chk (
    .clk(clk), .rst_n(rst_n), .cmp_in_ready(cmp_in_ready),
    .cmp_out_valid(cmp_out_valid), .cmp_out_ready(cmp_out_ready),
    .cmp_out_addr(cmp_out_addr), .cmp_out_tag(cmp_out_tag),
    .snp_out_valid(snp_out_valid), .snp_out_ready(snp_out_ready),
    .snp_out_addr(snp_out_addr), .snp_out_tag(snp_out_tag)
);

// File: tb/snoop_order_queue_tb.sv
module snoop_order_queue_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        cmp_in_valid = 1'b0, cmp_out_ready = 1'b0;
    logic [31:0] cmp_in_addr = '0;
    logic [3:0]  cmp_in_tag = '0;
    logic        snp_in_valid = 1'b0, snp_out_ready = 1'b0;
    logic [31:0] snp_in_addr = '0;
    logic [3:0]  snp_in_tag = '0;
    logic        cmp_in_ready, snp_in_ready, cmp_out_valid, snp_out_valid;
    logic [31:0] cmp_out_addr, snp_out_addr;
    logic [3:0]  cmp_out_tag, snp_out_tag;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    snoop_order_queue u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmp_in_valid(cmp_in_valid), .cmp_in_ready(cmp_in_ready),
        .cmp_in_addr(cmp_in_addr), .cmp_in_tag(cmp_in_tag),
        .snp_in_valid(snp_in_valid), .snp_in_ready(snp_in_ready),
        .snp_in_addr(snp_in_addr), .snp_in_tag(snp_in_tag),
        .cmp_out_valid(cmp_out_valid), .cmp_out_ready(cmp_out_ready),
        .cmp_out_addr(cmp_out_addr), .cmp_out_tag(cmp_out_tag),
        .snp_out_valid(snp_out_valid), .snp_out_ready(snp_out_ready),
        .snp_out_addr(snp_out_addr), .snp_out_tag(snp_out_tag)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic push_cmp(input logic [31:0] a, input logic [3:0] t);
        cmp_in_valid = 1'b1; cmp_in_addr = a; cmp_in_tag = t;
        step();
        cmp_in_valid = 1'b0;
    endtask

    task automatic push_snp(input logic [31:0] a, input logic [3:0] t);
        snp_in_valid = 1'b1; snp_in_addr = a; snp_in_tag = t;
        step();
        snp_in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "cmp_out_valid", 32'(cmp_out_valid), 0);
        check("R1", "snp_out_valid", 32'(snp_out_valid), 0);
        check("R1", "cmp_in_ready", 32'(cmp_in_ready), 1);
        check("R1", "snp_in_ready", 32'(snp_in_ready), 1);
    endtask

    task automatic t_order();
        cmp_out_ready = 1'b0;
        push_cmp(32'h100, 4'd1);
        push_cmp(32'h140, 4'd2);
        push_cmp(32'h180, 4'd3);
        check("R2", "head tag", 32'(cmp_out_tag), 1);
        step();
        check("R9", "held tag", 32'(cmp_out_tag), 1);
        check("R9", "held addr", cmp_out_addr, 32'h100);
        cmp_out_ready = 1'b1;
        step();
        check("R2", "second tag", 32'(cmp_out_tag), 2);
        check("R2", "second addr", cmp_out_addr, 32'h140);
        step();
        check("R2", "third tag", 32'(cmp_out_tag), 3);
        step();
        check("R2", "drained", 32'(cmp_out_valid), 0);
        cmp_out_ready = 1'b0;
    endtask

    task automatic t_bypass();
        cmp_out_ready = 1'b0; snp_out_ready = 1'b0;
        push_cmp(32'h1040, 4'd1);
        push_snp(32'h1080, 4'd5);
        check("R3", "snoop offered past older cmp", 32'(snp_out_valid), 1);
        check("R5", "bit6 differs -> no match, tag", 32'(snp_out_tag), 5);
        check("R3", "older cmp still pending", 32'(cmp_out_valid), 1);
        snp_out_ready = 1'b1;
        step();
        check("R3", "snoop taken", 32'(snp_out_valid), 0);
        cmp_out_ready = 1'b1;
        step();
        check("R3", "cmp drained", 32'(cmp_out_valid), 0);
        cmp_out_ready = 1'b0;
    endtask

    task automatic t_block();
        cmp_out_ready = 1'b0; snp_out_ready = 1'b1;
        push_cmp(32'h1040, 4'd1);
        push_cmp(32'h2000, 4'd2);
        push_cmp(32'h107F, 4'd3);
        push_snp(32'h1050, 4'd7);
        check("R4", "snoop held", 32'(snp_out_valid), 0);
        cmp_out_ready = 1'b1;
        step();
        check("R4", "held after first blocker", 32'(snp_out_valid), 0);
        check("R2", "tag 2 next", 32'(cmp_out_tag), 2);
        step();
        check("R5", "offset-only difference still blocks", 32'(snp_out_valid), 0);
        step();
        check("R4", "released after last blocker", 32'(snp_out_valid), 1);
        check("R4", "released tag", 32'(snp_out_tag), 7);
        check("R4", "completions gone", 32'(cmp_out_valid), 0);
        step();
        check("R4", "snoop taken", 32'(snp_out_valid), 0);
        cmp_out_ready = 1'b0; snp_out_ready = 1'b0;
    endtask

    task automatic t_same_cycle();
        cmp_out_ready = 1'b0; snp_out_ready = 1'b0;
        cmp_in_valid = 1'b1; cmp_in_addr = 32'h3000; cmp_in_tag = 4'd4;
        snp_in_valid = 1'b1; snp_in_addr = 32'h3010; snp_in_tag = 4'd9;
        step();
        cmp_in_valid = 1'b0; snp_in_valid = 1'b0;
        check("R6", "same-cycle cmp does not block", 32'(snp_out_valid), 1);
        push_cmp(32'h3020, 4'd6);
        check("R6", "later cmp does not block", 32'(snp_out_valid), 1);
        check("R6", "snoop tag", 32'(snp_out_tag), 9);
        cmp_out_ready = 1'b1; snp_out_ready = 1'b1;
        step();
        check("R6", "snoop taken", 32'(snp_out_valid), 0);
        check("R2", "cmp tag 6 next", 32'(cmp_out_tag), 6);
        step();
        check("R2", "cmp drained", 32'(cmp_out_valid), 0);
        cmp_out_ready = 1'b0; snp_out_ready = 1'b0;
    endtask

    task automatic t_cmp_full();
        cmp_out_ready = 1'b0;
        for (int i = 0; i < 8; i++) push_cmp(32'h4000 + 32'(i) * 64, 4'(i));
        check("R7", "full -> not ready", 32'(cmp_in_ready), 0);
        cmp_in_valid = 1'b1; cmp_in_addr = 32'h9000; cmp_in_tag = 4'hF;
        step(); step();
        cmp_in_valid = 1'b0;
        check("R7", "still not ready", 32'(cmp_in_ready), 0);
        cmp_out_ready = 1'b1;
        for (int i = 0; i < 8; i++) begin
            check("R7", "entry tag", 32'(cmp_out_tag), 32'(i));
            step();
        end
        check("R7", "refused entry absent", 32'(cmp_out_valid), 0);
        cmp_out_ready = 1'b0;
    endtask

    task automatic t_snp_full();
        snp_out_ready = 1'b0;
        for (int i = 0; i < 4; i++) push_snp(32'h5000 + 32'(i) * 64, 4'(8 + i));
        check("R8", "full -> not ready", 32'(snp_in_ready), 0);
        snp_out_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            check("R8", "snoop order tag", 32'(snp_out_tag), 32'(8 + i));
            step();
        end
        check("R8", "drained", 32'(snp_out_valid), 0);
        check("R8", "ready again", 32'(snp_in_ready), 1);
        snp_out_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) step();
        check("R1", "valid during reset", 32'(cmp_out_valid | snp_out_valid), 0);
        rst_n = 1'b1;
        step();
        t_reset();
        t_order();
        t_bypass();
        t_block();
        t_same_cycle();
        t_cmp_full();
        t_snp_full();
        finish_run();
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end
endmodule